// File: doc/BRIEF.md
# Embedded-Sync Video Word Parser

This block sits on a parallel video input clocked by the source and turns a raw stream of 8-bit or 10-bit words into a qualified word stream. Line and field timing is carried inside the stream as four-word timing codes. The parser finds those codes, checks their protection bits, and keeps track of the current field, the vertical-blank state, and whether the stream is inside the active part of a line.

Two forwarding modes are available. In the full-stream mode every word that is not part of a valid timing code is passed on. In the picture-only mode only words between a start-of-active code and the next end-of-active code are passed on, and only on lines outside vertical blanking. Each forwarded word carries a start-of-line marker and the field and blanking flags in force. The input clock is expected to run at half the system rate or less. The input bus is parameterised and defaults to 10 bits.

Top module: `vid656_parser`

## Requirements
- R1: With `wide_mode`=0 the code is matched on `in_data[7:0]` and a forwarded word is `in_data[7:0]` zero-extended. With `wide_mode`=1 the code is matched on `in_data[9:2]`, so the two low bits are ignored, and the whole input word is forwarded.
- R2: A timing code is four consecutive words whose keys are 0xFF, 0x00, 0x00 and a status key. None of these four words is ever forwarded.
- R3: Status key bit 7 is 1, bit 6 is the field flag, bit 5 is the vertical-blank flag, and bit 4 is 1 for end-of-active or 0 for start-of-active. A valid code sets the field flag seen on later words.
- R4: Status bits 3..0 must equal {V^H, F^H, F^V, F^V^H}, and bit 7 must be 1. Otherwise the four words count as ordinary data and the parser state is unchanged.
- R5: With `active_only`=1 a word is forwarded only if the last valid code was start-of-active and carried V=0.
- R6: With `active_only`=0 every word that is not part of a valid code is forwarded.
- R7: `out_sol` is high on a forwarded word that is the first non-code word after a start-of-active code. It is never high without `out_valid`.
- R8: `out_vblank` shows the V flag of the most recent valid code, together with each forwarded word.
- R9: A word sampled at clock edge k leaves on `out_*` after edge k+4. Nothing is forwarded in the first four cycles after reset.
- R10: While `rst` is high, and after it is released, `out_valid` and `out_sol` are low. Field, blanking and active state reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video word clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects 10-bit words, 0 selects 8-bit words |
| active_only | input | 1 | 1 forwards picture words only, 0 forwards all non-code words |
| in_data | input | DATA_W | Incoming video word, one per clock |
| out_valid | output | 1 | Forwarded word present |
| out_data | output | DATA_W | Forwarded word |
| out_sol | output | 1 | First word after a start-of-active code |
| out_field | output | 1 | Field flag of the latest valid code |
| out_vblank | output | 1 | Vertical-blank flag of the latest valid code |

## Verification
The bench targets overlapping candidates such as FF 00 00 FF 00 00 status. A parser that locks on the first FF would drop the wrong words or leak part of the code. It also sends codes whose protection bits are wrong, or whose bit 7 is clear. A design that skips the check would swallow data and flip the field or blank state. Other cases are a start code followed at once by an end code, which must produce no start-of-line marker, and random garbage in the unused bits of either width mode, which a wrong key slice would mistake for sync. Cycle-exact comparison in both forwarding modes catches any latency slip or any code word that leaks through.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

  localparam int PREAMBLE_WORDS = 4;
  localparam int KEY_W          = 8;
  localparam int WIDE_KEY_LSB   = 2;
  localparam logic [KEY_W-1:0] KEY_ONES  = 8'hFF;
  localparam logic [KEY_W-1:0] KEY_ZEROS = 8'h00;

  typedef struct packed {
    logic field;
    logic vblank;
    logic eav;
  } tref_t;

  function automatic logic status_ok(input logic [KEY_W-1:0] k);
    logic f, v, h;
    f = k[6];
    v = k[5];
    h = k[4];
    return k[7] && (k[3] == (v ^ h)) && (k[2] == (f ^ h)) &&
           (k[1] == (f ^ v)) && (k[0] == (f ^ v ^ h));
  endfunction

endpackage

// File: rtl/vid656_window.sv
module vid656_window #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DATA_W-1:0]             din,
  input  logic                          det,
  output logic [DEPTH-1:0][DATA_W-1:0]  taps,
  output logic [DEPTH-1:0]              fill,
  output logic [DEPTH-1:0]              kill
);

  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
      fill <= '0;
      kill <= '0;
    end else begin
      taps[0] <= din;
      fill[0] <= 1'b1;
      kill[0] <= 1'b0;
      for (int s = 1; s < DEPTH; s++) begin
        taps[s] <= taps[s-1];
        fill[s] <= fill[s-1];
        kill[s] <= kill[s-1] | det;
      end
    end
  end

endmodule

// File: rtl/vid656_code_detect.sv
module vid656_code_detect
  import vid656_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 4
) (
  input  logic                          wide_mode,
  input  logic [DEPTH-1:0][DATA_W-1:0]  taps,
  input  logic                          full,
  output logic                          det,
  output tref_t                         code
);

  logic [DEPTH-1:0][KEY_W-1:0] key;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_key
      assign key[g] = wide_mode ? taps[g][WIDE_KEY_LSB +: KEY_W]
                                : taps[g][KEY_W-1:0];
    end
  endgenerate

  always_comb begin
    det = full && (key[DEPTH-1] == KEY_ONES);
    for (int s = 1; s < DEPTH-1; s++) begin
      det = det && (key[s] == KEY_ZEROS);
    end
    det = det && status_ok(key[0]);
    code.field  = key[0][6];
    code.vblank = key[0][5];
    code.eav    = key[0][4];
  end

endmodule

// File: rtl/vid656_gate.sv
module vid656_gate
  import vid656_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic              active_only,
  input  logic [DATA_W-1:0] word,
  input  logic              word_fill,
  input  logic              word_kill,
  input  logic              det,
  input  tref_t             code,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sol,
  output logic              out_field,
  output logic              out_vblank,
  output logic              st_field,
  output logic              st_vblank
);

  logic act_q;
  logic sol_pend;
  logic emit;
  logic pass;

  assign emit = word_fill && !word_kill && !det;
  assign pass = emit && (!active_only || (act_q && !st_vblank));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= 1'b0;
      sol_pend   <= 1'b0;
      st_field   <= 1'b0;
      st_vblank  <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sol    <= 1'b0;
      out_field  <= 1'b0;
      out_vblank <= 1'b0;
    end else begin
      out_valid  <= pass;
      out_sol    <= pass && sol_pend;
      out_field  <= st_field;
      out_vblank <= st_vblank;
      if (!pass)          out_data <= '0;
      else if (wide_mode) out_data <= word;
      else                out_data <= {{(DATA_W-KEY_W){1'b0}}, word[KEY_W-1:0]};
      if (det) begin
        st_field  <= code.field;
        st_vblank <= code.vblank;
        act_q     <= !code.eav;
        sol_pend  <= !code.eav;
      end else if (emit) begin
        sol_pend  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vid656_parser.sv
module vid656_parser
  import vid656_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic              active_only,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sol,
  output logic              out_field,
  output logic              out_vblank
);

  localparam int DEPTH = PREAMBLE_WORDS;

  logic [DEPTH-1:0][DATA_W-1:0] taps;
  logic [DEPTH-1:0]             fill;
  logic [DEPTH-1:0]             kill;
  logic                         code_det;
  tref_t                        code;
  logic                         st_field;
  logic                         st_vblank;

  vid656_window #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_window (
    .clk  (clk),
    .rst  (rst),
    .din  (in_data),
    .det  (code_det),
    .taps (taps),
    .fill (fill),
    .kill (kill)
  );

  vid656_code_detect #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_detect (
    .wide_mode (wide_mode),
    .taps      (taps),
    .full      (fill[DEPTH-1]),
    .det       (code_det),
    .code      (code)
  );

  vid656_gate #(.DATA_W(DATA_W)) i_gate (
    .clk         (clk),
    .rst         (rst),
    .wide_mode   (wide_mode),
    .active_only (active_only),
    .word        (taps[DEPTH-1]),
    .word_fill   (fill[DEPTH-1]),
    .word_kill   (kill[DEPTH-1]),
    .det         (code_det),
    .code        (code),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_sol     (out_sol),
    .out_field   (out_field),
    .out_vblank  (out_vblank),
    .st_field    (st_field),
    .st_vblank   (st_vblank)
  );

endmodule

// File: rtl/vid656_checker.sv
module vid656_checker #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_mode,
  input logic              active_only,
  input logic              out_valid,
  input logic [DATA_W-9:0] data_hi,
  input logic              out_sol,
  input logic              out_vblank,
  input logic              det,
  input logic              st_field,
  input logic              st_vblank
);

  assert_sol_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
    out_sol |-> out_valid);

  assert_narrow_zero_ext_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !wide_mode) |-> (data_hi == '0));

  assert_no_blank_picture_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && active_only) |-> !out_vblank);

  assert_state_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !det |=> ($stable(st_field) && $stable(st_vblank)));

  assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_sol));

endmodule

bind vid656_parser vid656_checker #(.DATA_W(DATA_W)) i_checker (
  .clk         (clk),
  .rst         (rst),
  .wide_mode   (wide_mode),
  .active_only (active_only),
  .out_valid   (out_valid),
  .data_hi     (out_data[DATA_W-1:8]),
  .out_sol     (out_sol),
  .out_vblank  (out_vblank),
  .det         (code_det),
  .st_field    (st_field),
  .st_vblank   (st_vblank)
);

// File: tb/test_vid656_parser.sv
module test_vid656_parser;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 10;
  localparam int NMAX   = 1024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wide_mode = 1'b0;
  logic              active_only = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  logic              out_sol;
  logic              out_field;
  logic              out_vblank;

  int tests = 0;
  int fails = 0;

  logic [9:0] stim [NMAX];
  bit         pre  [NMAX];
  bit         killd[NMAX];
  bit         badp [NMAX];
  bit         ev   [NMAX];
  bit         es   [NMAX];
  bit         ef   [NMAX];
  bit         evb  [NMAX];
  logic [9:0] ed   [NMAX];
  int         n;
  bit         wide_cur;

  vid656_parser #(.DATA_W(DATA_W)) i_vid656_parser (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .active_only(active_only),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_sol(out_sol), .out_field(out_field), .out_vblank(out_vblank)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkstat(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [7:0] key_of(input logic [9:0] w, input bit wide);
    return wide ? w[9:2] : w[7:0];
  endfunction

  task automatic push(input logic [9:0] w);
    if (n < NMAX) begin
      stim[n] = w;
      n++;
    end
  endtask

  function automatic logic [9:0] kw(input logic [7:0] k);
    logic [1:0] r = 2'($urandom);
    return wide_cur ? {k, r} : {r, k};
  endfunction

  task automatic put_code(input logic [7:0] st);
    push(kw(8'hFF));
    push(kw(8'h00));
    push(kw(8'h00));
    push(kw(st));
  endtask

  task automatic put_data(input int cnt);
    for (int i = 0; i < cnt; i++) push(10'($urandom));
  endtask

  task automatic gen_stream();
    n = 0;
    // overlapping candidate: only the second one is a code
    push(kw(8'hFF)); push(kw(8'h00)); push(kw(8'h00));
    put_code(mkstat(1'b0, 1'b0, 1'b0));
    put_data(4);
    // end code, start code at once, end code at once (empty picture)
    put_code(mkstat(1'b0, 1'b0, 1'b1));
    put_code(mkstat(1'b1, 1'b0, 1'b0));
    put_code(mkstat(1'b1, 1'b0, 1'b1));
    put_data(3);
    // bad protection and bad bit 7: must act as data
    put_code(mkstat(1'b1, 1'b0, 1'b0) ^ 8'h01);
    put_data(2);
    put_code(mkstat(1'b0, 1'b1, 1'b0) & 8'h7F);
    put_data(2);
    put_code(mkstat(1'b1, 1'b0, 1'b0));
    put_data(5);
    for (int ln = 0; ln < 40 && n < NMAX - 60; ln++) begin
      bit f = 1'($urandom);
      bit v = ($urandom % 3) == 0;
      logic [7:0] s;
      s = mkstat(f, v, 1'b1);
      if (($urandom % 8) == 0) s = s ^ (8'h01 << ($urandom % 4));
      put_code(s);
      put_data(2 + int'($urandom % 8));
      s = mkstat(f, v, 1'b0);
      if (($urandom % 8) == 0) s = s ^ (8'h01 << ($urandom % 4));
      put_code(s);
      put_data(3 + int'($urandom % 18));
    end
  endtask

  task automatic build_model(input bit wide, input bit ao);
    bit act = 0, f = 0, v = 0, sp = 0;
    for (int i = 0; i < n; i++) begin
      pre[i] = 0; killd[i] = 0; badp[i] = 0;
    end
    for (int j = 3; j < n; j++) begin
      logic [7:0] k = key_of(stim[j], wide);
      bit lead = key_of(stim[j-3], wide) == 8'hFF &&
                 key_of(stim[j-2], wide) == 8'h00 &&
                 key_of(stim[j-1], wide) == 8'h00;
      pre[j] = lead && (k == mkstat(k[6], k[5], k[4]));
      for (int q = j - 3; q <= j; q++) begin
        if (pre[j]) killd[q] = 1;
        else if (lead) badp[q] = 1;
      end
    end
    for (int i = 0; i < n; i++) begin
      bit pass;
      if (i >= 1 && pre[i-1]) begin
        logic [7:0] k = key_of(stim[i-1], wide);
        f = k[6]; v = k[5]; act = !k[4]; sp = !k[4];
      end
      pass   = !killd[i] && (!ao || (act && !v));
      ev[i]  = pass;
      es[i]  = pass && sp;
      ef[i]  = f;
      evb[i] = v;
      ed[i]  = wide ? stim[i] : {2'b00, stim[i][7:0]};
      if (!killd[i]) sp = 0;
    end
  endtask

  task automatic run_phase(input bit wide, input bit ao);
    wide_cur = wide;
    gen_stream();
    build_model(wide, ao);
    @(negedge clk);
    rst = 1'b1;
    wide_mode = wide;
    active_only = ao;
    in_data = '0;
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", int'(out_valid), 0);
    chk("R10 sol in reset", int'(out_sol), 0);
    rst = 1'b0;
    for (int t = 0; t < n + 5; t++) begin
      in_data = (t < n) ? stim[t] : '0;
      if (t == 4) chk("R9 nothing before latency", int'(out_valid), 0);
      if (t >= 5) begin
        int w = t - 5;
        string tag;
        if (killd[w])     tag = "R2 code word gated";
        else if (badp[w]) tag = "R4 bad code as data";
        else if (ao)      tag = "R5 picture gating";
        else              tag = "R6 full stream";
        chk(tag, int'(out_valid), int'(ev[w]));
        if (ev[w] && out_valid) begin
          chk("R1 data", int'(out_data), int'(ed[w]));
          chk("R7 start of line", int'(out_sol), int'(es[w]));
          chk("R3 field flag", int'(out_field), int'(ef[w]));
          chk("R8 blank flag", int'(out_vblank), int'(evb[w]));
        end else begin
          chk("R7 no sol when idle", int'(out_sol), 0);
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd656));
    for (int p = 0; p < 4; p++) begin
      run_phase(p[1], p[0]);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule